// File: doc/BRIEF.md
# Pattern-Unlocked Serial Register Port

This block watches the cycles of an asynchronous memory-style bus and opens a one-bit serial path to a 64-bit clock register image. Each bus cycle arrives as a one-clock strobe with a chip-enable level and a read/write qualifier. While the port is locked, every access goes to memory. Write cycles are also compared, one data bit at a time, against a fixed 64-bit key. When 64 consecutive writes match the key, the port unlocks.

Once unlocked, the port takes a snapshot of the register image. The next 64 enabled cycles each move one bit on the data line. A read cycle drives the next snapshot bit out. A write cycle takes in a new bit. Memory is blocked for the whole transfer. If any bit was written, the assembled word is committed to the image when the transfer ends. An external active-low reset input can abort a transfer, unless a mask bit in the image tells the port to ignore it.

A read while locked always restarts recognition. The first wrong key bit freezes recognition until the next read.

Top module: `keyed_serial_port`

## Requirements
- R1: The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C (first byte in key bits 7:0), taken least significant bit first, one bit per enabled write on `dq0_in`. The write that matches key bit 63 pulses `snap_take` in its own cycle, and `mem_inhibit` is high from the next clock.
- R2: While locked, `mem_inhibit` is low for every access, including all the key writes.
- R3: While locked, an enabled read returns recognition to key bit 0 and clears any freeze. A full key sent after that read unlocks the port.
- R4: A write whose bit differs from the expected key bit freezes recognition. Later writes, even correct ones, are ignored until a read, so the port stays locked.
- R5: During transfer, `dq0_oe` is high exactly on enabled read cycles. Transfer cycle k (counting from 0) drives snapshot bit k of the image captured at unlock, with bit 0 first.
- R6: After the 64th transfer cycle, if at least one of those cycles was a write, `img_load` pulses for one clock on the next clock. In that cycle, bit k of `img_out` is the bit written in transfer cycle k, or snapshot bit k if cycle k was a read.
- R7: After the 64th transfer cycle, the port is locked again from the next clock, with recognition at key bit 0.
- R8: During transfer, while image bit 36 (the reset-mask bit) is 0, a low `ext_rst_n` aborts the transfer. The port is locked from the next clock, and no `img_load` follows.
- R9: While image bit 36 is 1, `ext_rst_n` has no effect, and the transfer runs to completion.
- R10: A strobe with `cyc_ce` low, and any clock without `cyc_stb`, leave both recognition and transfer state untouched.
- R11: A transfer made only of reads produces no `img_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; leaves the port locked at key bit 0 |
| cyc_stb | input | 1 | One-clock strobe marking a bus cycle |
| cyc_ce | input | 1 | Chip enable level for this cycle (1 = enabled) |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| dq0_in | input | 1 | Data line bit 0 seen during a write |
| ext_rst_n | input | 1 | External active-low transfer abort |
| img_in | input | 64 | Current clock register image; bit 36 is the reset mask |
| dq0_out | output | 1 | Serial bit driven during a transfer read |
| dq0_oe | output | 1 | Output enable for `dq0_out` |
| mem_inhibit | output | 1 | High while memory access is blocked |
| snap_take | output | 1 | Pulse: `img_in` is captured this clock |
| img_load | output | 1 | Pulse: `img_out` should be written into the image |
| img_out | output | 64 | Word to be committed |

## Verification
The bench sends the key cleanly, then sends it broken by a wrong bit, which tells a frozen matcher apart from one that only stalls. It also sends the key interrupted by a read, which shows that a read restarts recognition, and padded with disabled and non-strobe cycles, which shows that these cycles are transparent. Transfers are run as pure reads, pure writes and alternating read/write, which separates snapshot shift-out, commit of written bits, and the rule that suppresses commit when nothing was written. The abort input is then pulsed with the mask bit clear and with it set, to confirm that the abort is honoured in one case and ignored in the other.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic {
    PH_LOCKED = 1'b0,
    PH_XFER   = 1'b1
  } kp_phase_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic d;
  } kp_evt_t;
endpackage

// File: rtl/kp_key_matcher.sv
module kp_key_matcher
  import kp_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = 64'h5CA33AC55CA33AC5,
  localparam int PTR_W = $clog2(KEY_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  kp_evt_t          ev,
  input  logic             restart,
  output logic             key_done,
  output logic [PTR_W-1:0] ptr_o,
  output logic             frozen_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             frozen_q;
  logic             hit;

  function automatic logic want_bit(input logic [PTR_W-1:0] p);
    return KEY[p];
  endfunction

  assign hit      = en && ev.wr && !frozen_q && (ev.d == want_bit(ptr_q));
  assign key_done = hit && (ptr_q == PTR_W'(KEY_W - 1));
  assign ptr_o    = ptr_q;
  assign frozen_o = frozen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
    end else if (restart || (en && ev.rd)) begin
      ptr_q    <= '0;
      frozen_q <= 1'b0;
    end else if (en && ev.wr && !frozen_q) begin
      if (hit) ptr_q <= key_done ? '0 : ptr_q + 1'b1;
      else     frozen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/kp_bit_shifter.sv
module kp_bit_shifter #(
  parameter int XFER_W = 64,
  localparam int CNT_W = $clog2(XFER_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XFER_W-1:0] load_val,
  input  logic              step,
  input  logic              step_wr,
  input  logic              d,
  output logic              dout,
  output logic [XFER_W-1:0] img,
  output logic              last_step
);
  logic [XFER_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_bit;

  assign in_bit    = step_wr ? d : sh_q[0];
  assign last_step = step && (cnt_q == CNT_W'(XFER_W - 1));
  assign dout      = sh_q[0];
  assign img       = sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= load_val;
      cnt_q <= '0;
    end else if (step) begin
      sh_q  <= {in_bit, sh_q[XFER_W-1:1]};
      cnt_q <= last_step ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/keyed_serial_port.sv
module keyed_serial_port
  import kp_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = 64'h5CA33AC55CA33AC5,
  parameter int XFER_W = 64,
  parameter int MASK_POS = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              cyc_ce,
  input  logic              cyc_wr,
  input  logic              dq0_in,
  input  logic              ext_rst_n,
  input  logic [XFER_W-1:0] img_in,
  output logic              dq0_out,
  output logic              dq0_oe,
  output logic              mem_inhibit,
  output logic              snap_take,
  output logic              img_load,
  output logic [XFER_W-1:0] img_out
);
  localparam int PTR_W = $clog2(KEY_W);

  kp_phase_e        phase_q;
  kp_evt_t          evt;
  logic             in_xfer;
  logic             abort_w;
  logic             step_w;
  logic             key_done_w;
  logic             last_w;
  logic             restart_w;
  logic             wrote_q;
  logic             load_q;
  logic [PTR_W-1:0] ptr_w;
  logic             frozen_w;

  assign evt.rd    = cyc_stb && cyc_ce && !cyc_wr;
  assign evt.wr    = cyc_stb && cyc_ce && cyc_wr;
  assign evt.d     = dq0_in;
  assign in_xfer   = (phase_q == PH_XFER);
  assign abort_w   = in_xfer && !ext_rst_n && !img_in[MASK_POS];
  assign step_w    = in_xfer && !abort_w && (evt.rd || evt.wr);
  assign restart_w = abort_w || last_w;

  kp_key_matcher #(.KEY_W(KEY_W), .KEY(KEY)) u_match (
    .clk(clk), .rst_n(rst_n), .en(!in_xfer), .ev(evt), .restart(restart_w),
    .key_done(key_done_w), .ptr_o(ptr_w), .frozen_o(frozen_w)
  );

  kp_bit_shifter #(.XFER_W(XFER_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(key_done_w), .load_val(img_in),
    .step(step_w), .step_wr(evt.wr), .d(dq0_in),
    .dout(dq0_out), .img(img_out), .last_step(last_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOCKED;
      wrote_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= last_w && (wrote_q || evt.wr);
      if (restart_w)       phase_q <= PH_LOCKED;
      else if (key_done_w) phase_q <= PH_XFER;
      if (key_done_w)              wrote_q <= 1'b0;
      else if (step_w && evt.wr)   wrote_q <= 1'b1;
    end
  end

  assign mem_inhibit = in_xfer;
  assign dq0_oe      = step_w && !cyc_wr;
  assign snap_take   = key_done_w;
  assign img_load    = load_q;
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_inhibit,
  input logic             dq0_oe,
  input logic             snap_take,
  input logic             img_load,
  input logic             abort_w,
  input logic             rd_ev,
  input logic [PTR_W-1:0] ptr,
  input logic             frozen
);
  assert_oe_needs_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq0_oe |-> mem_inhibit);

  assert_unlock_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take |=> mem_inhibit);

  assert_key_write_to_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take |-> !mem_inhibit);

  assert_read_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !mem_inhibit) |=> (ptr == '0 && !frozen));

  assert_frozen_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rd_ev && !mem_inhibit) |=> (frozen && $stable(ptr)));

  assert_abort_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!mem_inhibit && !img_load));

  assert_load_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    img_load |-> ($past(mem_inhibit) && !mem_inhibit));

  assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snap_take, img_load, abort_w}));
endmodule

bind keyed_serial_port kp_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_inhibit(mem_inhibit), .dq0_oe(dq0_oe),
  .snap_take(snap_take), .img_load(img_load), .abort_w(abort_w),
  .rd_ev(evt.rd), .ptr(ptr_w), .frozen(frozen_w)
);

// File: tb/keyed_serial_port_test.sv
`timescale 1ns/1ps
module keyed_serial_port_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, stb, ce, wr, din, ext_n;
  logic [63:0] img;
  logic dout, oe, mi, snap, ld;
  logic [63:0] iout;

  keyed_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(stb), .cyc_ce(ce), .cyc_wr(wr),
    .dq0_in(din), .ext_rst_n(ext_n), .img_in(img), .dq0_out(dout),
    .dq0_oe(oe), .mem_inhibit(mi), .snap_take(snap), .img_load(ld),
    .img_out(iout)
  );

  int n_tests = 0, n_fail = 0;

  // behavioural reference model state
  bit m_ph; int m_ptr; bit m_frz; int m_cnt; bit m_anyw; bit m_ldp;
  bit m_snap[64]; bit m_new[64]; logic [63:0] m_ldv;
  logic g_dout, g_mi, g_ld; logic [63:0] g_iout;

  function automatic bit keyb(int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit s, bit c, bit w, bit d, bit r);
    bit rd, wv, ab, e_oe, e_snap;
    stb = s; ce = c; wr = w; din = d; ext_n = r;
    #1;
    rd = s && c && !w; wv = s && c && w;
    ab = m_ph && !r && !img[36];
    e_oe = m_ph && !ab && rd;
    e_snap = !m_ph && wv && !m_frz && (d == keyb(m_ptr)) && (m_ptr == 63);
    check("R2", "mem_inhibit", mi, m_ph);
    check("R5", "dq0_oe", oe, e_oe);
    if (e_oe) check("R5", "dq0_out", dout, m_snap[m_cnt]);
    check("R1", "snap_take", snap, e_snap);
    check("R6", "img_load", ld, m_ldp);
    if (m_ldp) check("R6", "img_out", iout, m_ldv);
    g_dout = dout; g_mi = mi; g_ld = ld; g_iout = iout;
    m_ldp = 0;
    if (m_ph) begin
      if (ab) begin
        m_ph = 0; m_ptr = 0; m_frz = 0;
      end else if (rd || wv) begin
        m_new[m_cnt] = wv ? d : m_snap[m_cnt];
        m_anyw |= wv;
        m_cnt++;
        if (m_cnt == 64) begin
          m_ph = 0; m_ptr = 0; m_frz = 0;
          if (m_anyw) begin
            m_ldp = 1;
            for (int k = 0; k < 64; k++) m_ldv[k] = m_new[k];
          end
        end
      end
    end else if (rd) begin
      m_ptr = 0; m_frz = 0;
    end else if (wv && !m_frz) begin
      if (d == keyb(m_ptr)) begin
        if (m_ptr == 63) begin
          m_ph = 1; m_cnt = 0; m_anyw = 0;
          for (int k = 0; k < 64; k++) m_snap[k] = img[k];
        end else m_ptr++;
      end else m_frz = 1;
    end
    @(negedge clk);
  endtask

  task automatic rd_c();           cyc(1, 1, 0, 0, 1); endtask
  task automatic wr_c(bit d);      cyc(1, 1, 1, d, 1); endtask
  task automatic send_key(int from, int to, bit gaps);
    for (int i = from; i <= to; i++) begin
      if (gaps) begin
        cyc(1, 0, 1, ~keyb(i), 1);
        cyc(0, 1, 0, 0, 1);
      end
      wr_c(keyb(i));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] got, wdat, base;
    base = 64'h0123_4567_89AB_CDEF;   // bit 36 = 0
    img = base; rst_n = 0; stb = 0; ce = 0; wr = 0; din = 0; ext_n = 1;
    m_ph = 0; m_ptr = 0; m_frz = 0; m_cnt = 0; m_anyw = 0; m_ldp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R2", "reset mem_inhibit", mi, 0);
    check("R6", "reset img_load", ld, 0);
    @(negedge clk);

    // R1 + R5 + R11: clean key, full read-out
    rd_c(); send_key(0, 63, 0);
    cyc(0, 0, 0, 0, 1);
    check("R1", "unlocked after key", g_mi, 1);
    img = 64'hFFFF_0000_FFFF_0000;      // later changes must not leak in
    got = '0;
    for (int k = 0; k < 64; k++) begin rd_c(); got[k] = g_dout; end
    check("R5", "snapshot read-out", got, base);
    cyc(0, 0, 0, 0, 1);
    check("R7", "locked after 64 cycles", g_mi, 0);
    check("R11", "no load after read-only", g_ld, 0);
    img = base;

    // R6: write transfer
    wdat = 64'hDEAD_BEEF_0BAD_F00D;
    rd_c(); send_key(0, 63, 0);
    for (int k = 0; k < 64; k++) wr_c(wdat[k]);
    cyc(0, 0, 0, 0, 1);
    check("R6", "load pulse", g_ld, 1);
    check("R6", "committed word", g_iout, wdat);
    cyc(0, 0, 0, 0, 1);
    check("R6", "load single pulse", g_ld, 0);

    // R4: mismatch freezes even if the rest is right
    rd_c(); send_key(0, 9, 0); wr_c(~keyb(10)); send_key(11, 63, 0);
    send_key(0, 63, 0);
    cyc(0, 0, 0, 0, 1);
    check("R4", "still locked after mismatch", g_mi, 0);

    // R3: read midway restarts
    rd_c(); send_key(0, 19, 0); rd_c(); send_key(0, 63, 0);
    cyc(0, 0, 0, 0, 1);
    check("R3", "unlock after restart", g_mi, 1);
    // mixed transfer with R10 gaps
    for (int k = 0; k < 64; k++) begin
      cyc(1, 0, k[0], 1, 1);
      if (k[0]) rd_c(); else wr_c(k[1]);
    end
    cyc(0, 0, 0, 0, 1);
    check("R6", "mixed transfer load", g_ld, 1);

    // R10: key padded with disabled cycles
    rd_c(); send_key(0, 63, 1);
    cyc(0, 0, 0, 0, 1);
    check("R10", "key with gaps unlocks", g_mi, 1);
    // R8: abort after 10 writes
    for (int k = 0; k < 10; k++) wr_c(1);
    cyc(1, 1, 1, 1, 0);
    cyc(0, 0, 0, 0, 1);
    check("R8", "abort relocks", g_mi, 0);
    check("R8", "abort no load", g_ld, 0);
    for (int k = 0; k < 70; k++) wr_c(0);
    check("R8", "no load after abort", g_ld, 0);

    // R9: mask set, reset input ignored
    img = base ^ (64'h1 << 36);
    rd_c(); send_key(0, 63, 0);
    for (int k = 0; k < 64; k++) cyc(1, 1, 1, k[2], k[0]);
    cyc(0, 0, 0, 0, 1);
    check("R9", "masked reset completes", g_ld, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule